// File: doc/BRIEF.md
# Reverse-Current Recovery Sequencer

This block supervises reverse-current protection for a pass switch made of an internal device and an external gate-driven device. It watches two comparator flags that report the input-minus-output voltage falling below a tight threshold and below a loose threshold. On a reverse event it commands both devices off and holds them off for a fixed recovery time. It then waits for the condition to clear, waits a restart delay chosen from the output voltage, and asks the startup sequencer for a fresh full startup.

After each startup-complete strobe, the loose threshold is used for a fixed window, so that ringing at the end of startup does not cause a false trip. After the window the tight threshold is used. An enable pin gates detection. All times are counted in clock ticks and set by parameters: the loose window (`WIN_TICKS`), the recovery hold (`RECOV_TICKS`), and the two restart delays (`DLY_HI_TICKS` when the output is above its undervoltage level, `DLY_LO_TICKS` when it is not).

Top module: `rev_block_seq`

## Requirements
- R1: After reset, `gate_off` is 0, `thr_loose` is 0, `fault_n` is 1 and `restart_req` is 0.
- R2: A `start_done` strobe sampled while not tripped drives `thr_loose` to 1 for exactly `WIN_TICKS` cycles, starting the cycle after the strobe. `thr_loose` is 0 at all other times.
- R3: While not tripped, a trip is taken on a clock edge where `rev_en` is 1 and the selected flag is 1. The selected flag is `rev_loose` when `thr_loose` is 1 and `rev_tight` otherwise. A set `rev_tight` during the loose window does not trip.
- R4: From the cycle after a trip, `gate_off` is 1 and `fault_n` is 0 for `RECOV_TICKS` cycles, whatever the flags do.
- R5: If `rev_tight` (gated by `rev_en`) is still 1 at the last recovery edge, the block stays off until the first edge where it is 0.
- R6: At the edge where recovery ends with the condition clear, or where the condition clears, `out_ok` is sampled. The restart delay is then `DLY_HI_TICKS` cycles if `out_ok` is 1 and `DLY_LO_TICKS` cycles if it is 0.
- R7: A trip condition seen on any edge during the restart delay restarts the full recovery time.
- R8: When the restart delay ends, `restart_req` is 1 for exactly one cycle. In that same cycle `gate_off` returns to 0 and `fault_n` to 1.
- R9: A trip cancels the loose window at once, and `start_done` is ignored while tripped.
- R10: With `rev_en` at 0, no new trip is taken whatever the comparator flags show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rev_en | input | 1 | Reverse protection enable (1 = enabled) |
| rev_tight | input | 1 | Input minus output is below the tight threshold |
| rev_loose | input | 1 | Input minus output is below the loose threshold |
| out_ok | input | 1 | Output is at or above its undervoltage level |
| start_done | input | 1 | One-cycle strobe: startup has completed |
| gate_off | output | 1 | Command to turn both devices off |
| thr_loose | output | 1 | Selects the loose comparator threshold |
| fault_n | output | 1 | Fault flag, low while tripped |
| restart_req | output | 1 | One-cycle request for a full startup |

## Verification
The hardest cases to reach are the ones where an event lands exactly at a window edge. One is a second reverse event inside the restart delay. Another is the tight flag still being high on the very last recovery edge. A third is the last cycle of the loose window, where only the loose flag counts. The stimulus reaches each one by counting falling edges from a known trip or strobe edge. It pulses the flags for one sampled edge at a chosen offset, and it switches `out_ok` on the same edge the condition clears. The measured length of each off interval is then compared with the sum of recovery, hold-over and delay.

// File: rtl/rev_block_seq.sv
module rev_block_seq #(
  parameter int WIN_TICKS    = 1600,
  parameter int RECOV_TICKS  = 240,
  parameter int DLY_HI_TICKS = 42,
  parameter int DLY_LO_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rev_en,
  input  logic rev_tight,
  input  logic rev_loose,
  input  logic out_ok,
  input  logic start_done,
  output logic gate_off,
  output logic thr_loose,
  output logic fault_n,
  output logic restart_req
);
  localparam int DMAX = (DLY_HI_TICKS > DLY_LO_TICKS) ? DLY_HI_TICKS : DLY_LO_TICKS;
  localparam int TMAX = (RECOV_TICKS > DMAX) ? RECOV_TICKS : DMAX;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int WW   = $clog2(WIN_TICKS + 1);
  localparam logic [CW-1:0] RLOAD  = CW'(RECOV_TICKS - 1);
  localparam logic [CW-1:0] DHLOAD = CW'(DLY_HI_TICKS - 1);
  localparam logic [CW-1:0] DLLOAD = CW'(DLY_LO_TICKS - 1);
  localparam logic [WW-1:0] WLOAD  = WW'(WIN_TICKS);

  typedef enum logic [1:0] {WATCH, HOLD, STUCK, SETTLE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [WW-1:0] win;
  logic          hit;

  assign thr_loose = (win != '0);
  assign hit       = rev_en & (thr_loose ? rev_loose : rev_tight);
  assign gate_off  = (st != WATCH);
  assign fault_n   = (st == WATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= WATCH;
      cnt         <= '0;
      win         <= '0;
      restart_req <= 1'b0;
    end else begin
      restart_req <= 1'b0;
      case (st)
        WATCH: begin
          if (hit) begin
            st  <= HOLD;
            cnt <= RLOAD;
            win <= '0;
          end else if (start_done) begin
            win <= WLOAD;
          end else if (win != '0) begin
            win <= win - 1'b1;
          end
        end
        HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (hit) begin
            st <= STUCK;
          end else begin
            st  <= SETTLE;
            cnt <= out_ok ? DHLOAD : DLLOAD;
          end
        end
        STUCK: begin
          if (!hit) begin
            st  <= SETTLE;
            cnt <= out_ok ? DHLOAD : DLLOAD;
          end
        end
        default: begin
          if (hit) begin
            st  <= HOLD;
            cnt <= RLOAD;
          end else if (cnt == '0) begin
            st          <= WATCH;
            restart_req <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rev_block_seq_chk.sv
module rev_block_seq_chk #(
  parameter int RECOV_TICKS  = 240,
  parameter int DLY_HI_TICKS = 42,
  parameter int DLY_LO_TICKS = 50
) (
  input logic clk,
  input logic rst_n,
  input logic rev_en,
  input logic start_done,
  input logic gate_off,
  input logic thr_loose,
  input logic restart_req
);
  localparam int MIN_OFF = RECOV_TICKS + ((DLY_HI_TICKS < DLY_LO_TICKS) ? DLY_HI_TICKS : DLY_LO_TICKS);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else        run <= gate_off ? run + 1 : 0;
  end

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);
  // R8
  pulse_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (!gate_off && $past(gate_off)));
  // R4
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_off) |-> (run >= MIN_OFF));
  // R9
  window_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |-> !thr_loose);
  // R10
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_off && !rev_en) |=> !gate_off);
  // R2
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thr_loose) |-> $past(start_done));
endmodule

bind rev_block_seq rev_block_seq_chk #(
  .RECOV_TICKS(RECOV_TICKS), .DLY_HI_TICKS(DLY_HI_TICKS), .DLY_LO_TICKS(DLY_LO_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rev_en(rev_en), .start_done(start_done),
  .gate_off(gate_off), .thr_loose(thr_loose), .restart_req(restart_req)
);

// File: tb/tb_rev_block_seq.sv
`timescale 1ns/1ps
module tb_rev_block_seq;
  localparam int W  = 1600;
  localparam int R  = 240;
  localparam int DH = 42;
  localparam int DL = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rev_en = 1'b1, rev_tight = 1'b0, rev_loose = 1'b0, out_ok = 1'b1, start_done = 1'b0;
  logic gate_off, thr_loose, fault_n, restart_req;

  int checks = 0, errors = 0, cycles = 0;
  int run = 0, last_run = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  int m_phase, m_left, m_win;
  bit m_pulse;

  always #10 clk = ~clk;

  rev_block_seq dut (
    .clk(clk), .rst_n(rst_n), .rev_en(rev_en), .rev_tight(rev_tight),
    .rev_loose(rev_loose), .out_ok(out_ok), .start_done(start_done),
    .gate_off(gate_off), .thr_loose(thr_loose), .fault_n(fault_n),
    .restart_req(restart_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // behavioural reference: phase 0 watching, 1 recovery, 2 held over, 3 delay
  always @(posedge clk) begin
    bit trig;
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_win = 0; m_pulse = 0;
    end else begin
      trig = rev_en && ((m_win > 0) ? rev_loose : rev_tight);
      m_pulse = 0;
      if (m_phase == 0) begin
        if (trig) begin m_phase = 1; m_left = R; m_win = 0; end
        else if (start_done) m_win = W;
        else if (m_win > 0) m_win--;
      end else if (m_phase == 1) begin
        m_left--;
        if (m_left == 0) begin
          if (trig) m_phase = 2;
          else begin m_phase = 3; m_left = out_ok ? DH : DL; end
        end
      end else if (m_phase == 2) begin
        if (!trig) begin m_phase = 3; m_left = out_ok ? DH : DL; end
      end else begin
        if (trig) begin m_phase = 1; m_left = R; end
        else begin
          m_left--;
          if (m_left == 0) begin m_phase = 0; m_pulse = 1; end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (gate_off) run++;
    else if (run > 0) begin last_run = run; run = 0; end
    if (cmp_en) begin
      chk(gate_off == (m_phase != 0), "R4 gate_off vs model", gate_off, m_phase != 0);
      chk(fault_n == (m_phase == 0), "R4 fault_n vs model", fault_n, m_phase == 0);
      chk(thr_loose == (m_win > 0), "R2 thr_loose vs model", thr_loose, m_win > 0);
      chk(restart_req == m_pulse, "R8 restart_req vs model", restart_req, m_pulse);
    end
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_free();
    for (int i = 0; i < 5000 && gate_off; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tight(input int n);
    rev_tight = 1'b1;
    tick(n);
    rev_tight = 1'b0;
  endtask

  initial begin
    tick(3);
    chk(!gate_off && fault_n && !thr_loose && !restart_req, "R1 reset state",
        {gate_off, fault_n, thr_loose, restart_req}, 4'b0100);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    tick(2);

    // R2 / R3: window boundary with only the tight flag set
    start_done = 1'b1; tick(1); start_done = 1'b0;
    chk(thr_loose, "R2 first window cycle", thr_loose, 1);
    rev_tight = 1'b1;
    tick(W - 1);
    chk(thr_loose && !gate_off, "R3 last window cycle, tight ignored", {thr_loose, gate_off}, 2'b10);
    tick(1);
    chk(!thr_loose && !gate_off, "R2 window closed", {thr_loose, gate_off}, 2'b00);
    tick(1);
    rev_tight = 1'b0;
    chk(gate_off && !fault_n, "R3 trip on tight flag after window", gate_off, 1);
    wait_free();

    // R6 high branch, condition cleared at expiry
    out_ok = 1'b1;
    pulse_tight(1);
    wait_free();
    chk(last_run == R + DH, "R6 off length with output good", last_run, R + DH);

    // R6 low branch
    out_ok = 1'b0;
    pulse_tight(1);
    wait_free();
    chk(last_run == R + DL, "R6 off length with output low", last_run, R + DL);

    // R5: condition still present at expiry, out_ok sampled at clearing
    out_ok = 1'b1;
    rev_tight = 1'b1;
    tick(R + 30);
    rev_tight = 1'b0; out_ok = 1'b0;
    wait_free();
    chk(last_run == R + 30 + DL, "R5 held off until clear", last_run, R + 30 + DL);

    // R7: new event inside the restart delay
    out_ok = 1'b1;
    pulse_tight(1);
    tick(R + 4);
    chk(gate_off, "R7 in delay before second event", gate_off, 1);
    pulse_tight(1);
    wait_free();
    chk(last_run == 2 * R + 5 + DH, "R7 recovery restarted", last_run, 2 * R + 5 + DH);

    // R10: disabled protection ignores both flags
    rev_en = 1'b0; rev_tight = 1'b1; rev_loose = 1'b1;
    tick(20);
    chk(!gate_off && fault_n, "R10 no trip while disabled", gate_off, 0);
    rev_tight = 1'b0; rev_loose = 1'b0; rev_en = 1'b1;
    tick(2);

    // R9: trip inside window cancels it; strobe ignored while tripped
    start_done = 1'b1; tick(1); start_done = 1'b0;
    tick(5);
    rev_loose = 1'b1; rev_tight = 1'b1; tick(1); rev_loose = 1'b0; rev_tight = 1'b0;
    chk(gate_off && !thr_loose, "R9 window cancelled by trip", thr_loose, 0);
    tick(10);
    start_done = 1'b1; tick(1); start_done = 1'b0;
    chk(!thr_loose, "R9 strobe ignored while tripped", thr_loose, 0);
    for (int i = 0; i < 5000 && !restart_req; i++) @(negedge clk);
    chk(restart_req && !gate_off && fault_n, "R8 restart pulse releases gates",
        {restart_req, gate_off, fault_n}, 3'b101);
    tick(1);
    chk(!restart_req && !thr_loose, "R8 pulse is one cycle", restart_req, 0);
    tick(5);
    finish_run();
  end
endmodule